// File: doc/BRIEF.md
# Temperature Compensation Update Sequencer

This block runs the periodic compensation cycle of a digitally tuned crystal oscillator. A sensor front end hands it each finished temperature sample as a one-cycle valid strobe and a 10-bit signed value, counted in quarter degrees Celsius. The block stores the sample in a 16-bit readable temperature register. It then asks an external factory table for the compensation code at that temperature, using a request/acknowledge lookup port. It adds the user frequency-offset register to the returned code and drives the clamped sum onto the crystal-loading output.

The user offset is an 8-bit two's-complement value, about 0.05 ppm per LSB. It can be written at any moment. The block copies it when a new update cycle starts, so a write made during an update takes effect only at the next update. Both bytes of the temperature register change in the same clock, so software that reads the two bytes never sees halves of two different conversions. A free-running counter marks the conversion period with a single-cycle start pulse to the sensor front end.

Top module: `tcomp_sequencer`

## Requirements
- R1: While reset is asserted and right after it is released, temp_rd is 0000h, ofs_rd is 00h, lut_req is 0 and load_code equals the LOAD_INIT parameter (512 by default).
- R2: temp_rd holds the sample shifted left by six places. Bits 15..6 carry the 10-bit signed sample: bit 15 is the sign, then weights 2^6 down to 2^-2. Bits 5..0 read as zero. So +85 °C reads 5500h, +0.5 °C reads 0080h, -0.5 °C reads FF80h and -40 °C reads D800h.
- R3: Every cycle with smp_valid high loads a new value into all 16 bits of temp_rd on that clock edge. This includes cycles where a lookup is outstanding. In cycles without smp_valid, temp_rd does not change.
- R4: A sample accepted while no lookup is outstanding raises lut_req in the next cycle, with lut_temp equal to that sample. lut_req and lut_temp then stay unchanged until a cycle in which lut_ack is high.
- R5: On the edge where lut_req and lut_ack are both high, load_code takes the value lut_code plus the sign-extended captured offset, and lut_req drops. load_code changes at no other time.
- R6: A write (ofs_wr_en high) shows on ofs_rd after that clock edge. The offset used by an update cycle is the ofs_rd value in the cycle its sample is accepted. A write in the same cycle as the sample, or during the lookup, applies only from the next update cycle.
- R7: The sum saturates instead of wrapping. A negative sum gives load_code 0, and a sum above 2^LOAD_W-1 gives 2^LOAD_W-1 (1023 by default).
- R8: A sample that arrives while a lookup is outstanding starts no second lookup. lut_temp keeps the first sample, and lut_req is 0 in the cycle after the acknowledge.
- R9: conv_start is a one-cycle pulse that repeats every CONV_CYC clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| conv_start | output | 1 | One-cycle pulse marking each conversion period |
| smp_valid | input | 1 | A finished temperature sample is present |
| smp_data | input | TEMP_W | Signed sample, 0.25 °C per LSB |
| lut_req | output | 1 | Lookup request to the factory table |
| lut_temp | output | TEMP_W | Temperature the lookup is for |
| lut_ack | input | 1 | Table answer valid |
| lut_code | input | LOAD_W | Unsigned factory compensation code |
| ofs_wr_en | input | 1 | Write strobe for the offset register |
| ofs_wr_data | input | OFS_W | Two's-complement offset to write |
| ofs_rd | output | OFS_W | Current offset register |
| temp_rd | output | 16 | Temperature register |
| load_code | output | LOAD_W | Saturated crystal-loading code |

## Verification
The assertions check four things on every cycle:
- lut_req stays raised with a stable lut_temp until it is acknowledged.
- load_code and temp_rd change only on an acknowledge or on a sample, respectively.
- The offset register changes only on a write.
- conv_start never lasts two cycles.

Only the bench scenarios can show the rest:
- the values themselves: the register encoding of given temperatures, and the clamped sums at both limits;
- which offset an update uses when a write lands during a lookup or beside the sample;
- that a sample arriving while a lookup is outstanding updates the register but starts no new lookup;
- the exact conv_start period.

// File: rtl/tcomp_sequencer.sv
module tcomp_sequencer #(
  parameter int TEMP_W    = 10,
  parameter int OFS_W     = 8,
  parameter int LOAD_W    = 10,
  parameter int LOAD_INIT = 512,
  parameter int CONV_CYC  = 2500000
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              conv_start,
  input  logic              smp_valid,
  input  logic [TEMP_W-1:0] smp_data,
  output logic              lut_req,
  output logic [TEMP_W-1:0] lut_temp,
  input  logic              lut_ack,
  input  logic [LOAD_W-1:0] lut_code,
  input  logic              ofs_wr_en,
  input  logic [OFS_W-1:0]  ofs_wr_data,
  output logic [OFS_W-1:0]  ofs_rd,
  output logic [15:0]       temp_rd,
  output logic [LOAD_W-1:0] load_code
);
  localparam int PAD   = 16 - TEMP_W;
  localparam int SUM_W = LOAD_W + 2;
  localparam int CNT_W = $clog2(CONV_CYC);

  logic [TEMP_W-1:0] temp_q, addr_q;
  logic [OFS_W-1:0]  ofs_q, snap_q;
  logic [LOAD_W-1:0] load_q;
  logic              busy_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [SUM_W-1:0]  sum;
  logic [LOAD_W-1:0] sat;
  logic              done;

  assign done = busy_q & lut_ack;
  assign sum  = {2'b00, lut_code} + {{(SUM_W-OFS_W){snap_q[OFS_W-1]}}, snap_q};
  assign sat  = sum[SUM_W-1] ? '0 : (sum[LOAD_W] ? '1 : sum[LOAD_W-1:0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      temp_q <= '0;
      addr_q <= '0;
      ofs_q  <= '0;
      snap_q <= '0;
      load_q <= LOAD_W'(LOAD_INIT);
      busy_q <= 1'b0;
    end else begin
      if (ofs_wr_en) ofs_q <= ofs_wr_data;
      if (smp_valid) temp_q <= smp_data;
      if (smp_valid && !busy_q) begin
        addr_q <= smp_data;
        snap_q <= ofs_q;
        busy_q <= 1'b1;
      end else if (done) begin
        load_q <= sat;
        busy_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || cnt_q == CNT_W'(CONV_CYC - 1)) cnt_q <= '0;
    else                                       cnt_q <= cnt_q + 1'b1;
  end

  assign conv_start = rst_n && (cnt_q == CNT_W'(CONV_CYC - 1));
  assign lut_req    = busy_q;
  assign lut_temp   = addr_q;
  assign ofs_rd     = ofs_q;
  assign temp_rd    = {temp_q, {PAD{1'b0}}};
  assign load_code  = load_q;

  assert_req_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (lut_req && !lut_ack) |=> (lut_req && $stable(lut_temp)));
  assert_load_only_on_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(lut_req && lut_ack) |=> $stable(load_code));
  assert_temp_only_on_sample_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |=> $stable(temp_rd));
  assert_ofs_only_on_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !ofs_wr_en |=> $stable(ofs_rd));
  assert_start_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);
endmodule

// File: tb/sim_tcomp_sequencer.sv
module sim_tcomp_sequencer;
  localparam int CYC = 16;
  logic clk = 0, rst_n = 0;
  logic conv_start, smp_valid = 0, lut_req, lut_ack = 0, ofs_wr_en = 0;
  logic [9:0] smp_data = '0, lut_temp, lut_code = '0, load_code;
  logic [7:0] ofs_wr_data = '0, ofs_rd;
  logic [15:0] temp_rd;
  int checks = 0, fails = 0;
  logic [7:0] ofs_m = '0;
  bit done = 0;

  always #5 clk = ~clk;

  tcomp_sequencer #(.CONV_CYC(CYC)) u0 (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int sat(input int code, input logic [7:0] o);
    int s = code + int'($signed(o));
    return s < 0 ? 0 : (s > 1023 ? 1023 : s);
  endfunction

  task automatic wr_ofs(input logic [7:0] v);
    ofs_wr_en = 1; ofs_wr_data = v;
    @(negedge clk); ofs_wr_en = 0;
    ofs_m = v;
    chk("R6 ofs_rd after write", ofs_rd, v);
  endtask

  task automatic cycle(input logic [9:0] s, input logic [9:0] code, input int dly,
                       input bit mid_wr, input logic [7:0] mid_v,
                       input bit mid_smp, input logic [9:0] s2);
    logic [7:0] snap = ofs_m;
    int prev = load_code;
    smp_valid = 1; smp_data = s;
    @(negedge clk); smp_valid = 0;
    chk("R2 temp_rd encoding", temp_rd, {s, 6'b0});
    chk("R4 lut_req raised", lut_req, 1);
    chk("R4 lut_temp", lut_temp, s);
    if (mid_wr) wr_ofs(mid_v);
    if (mid_smp) begin
      smp_valid = 1; smp_data = s2;
      @(negedge clk); smp_valid = 0;
      chk("R3 temp_rd while busy", temp_rd, {s2, 6'b0});
      chk("R8 lut_temp kept", lut_temp, s);
    end
    for (int i = 0; i < dly; i++) @(negedge clk);
    chk("R5 load held before ack", load_code, prev);
    lut_ack = 1; lut_code = code;
    @(negedge clk); lut_ack = 0;
    chk("R5/R7 load_code", load_code, sat(code, snap));
    chk("R8 no new lookup", lut_req, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int last, n;
    @(posedge rst_n);
    last = -1; n = 0;
    for (int c = 0; c < 4 * CYC; c++) begin
      @(negedge clk);
      if (conv_start) begin
        if (last >= 0) chk("R9 conv_start period", c - last, CYC);
        last = c; n++;
      end
    end
    chk("R9 pulse count", n >= 3, 1);
  end

  initial begin
    void'($urandom(1234));
    repeat (3) @(negedge clk);
    chk("R1 temp_rd in reset", temp_rd, 0);
    chk("R1 load_code in reset", load_code, 512);
    rst_n = 1;
    @(negedge clk);
    chk("R1 temp_rd", temp_rd, 0);
    chk("R1 ofs_rd", ofs_rd, 0);
    chk("R1 lut_req", lut_req, 0);
    chk("R1 load_code", load_code, 512);
    lut_ack = 1; lut_code = 10'd5;
    @(negedge clk); lut_ack = 0;
    chk("R5 stray ack ignored", load_code, 512);

    cycle(10'h154, 10'd300, 1, 0, 0, 0, 0);
    cycle(10'h3FE, 10'd400, 0, 0, 0, 0, 0);
    cycle(10'h002, 10'd100, 2, 0, 0, 0, 0);
    cycle(10'h360, 10'd700, 1, 0, 0, 0, 0);
    wr_ofs(8'h7F);
    cycle(10'h050, 10'd1000, 1, 0, 0, 0, 0);
    cycle(10'h051, 10'd1023, 0, 1, 8'h80, 0, 0);
    cycle(10'h052, 10'd50, 1, 0, 0, 0, 0);
    wr_ofs(8'hFF);
    cycle(10'h053, 10'd1023, 0, 0, 0, 1, 10'h3C0);
    cycle(10'h054, 10'd0, 0, 0, 0, 0, 0);
    smp_valid = 1; smp_data = 10'h011; ofs_wr_en = 1; ofs_wr_data = 8'h10;
    @(negedge clk); smp_valid = 0; ofs_wr_en = 0;
    lut_ack = 1; lut_code = 10'd200;
    @(negedge clk); lut_ack = 0;
    chk("R6 same-cycle write not used", load_code, sat(200, 8'hFF));
    ofs_m = 8'h10;
    cycle(10'h012, 10'd200, 0, 0, 0, 0, 0);

    for (int k = 0; k < 40; k++) begin
      if ($urandom_range(3) == 0) wr_ofs(8'($urandom));
      cycle(10'($urandom), 10'($urandom), $urandom_range(3),
            $urandom_range(4) == 0, 8'($urandom),
            $urandom_range(5) == 0, 10'($urandom));
    end
    repeat (4 * CYC) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule